// File: doc/BRIEF.md
# Lifting-Step Two-Channel Wavelet Analysis Bank

This block splits a serial stream of signed 16-bit audio samples into a low-pass and a high-pass coefficient stream. Each of these streams runs at half the input rate. The filter pair is an 8-tap fourth-order Daubechies basis. It is factored into five lifting steps that alternate between the two phases, and a gain on each channel follows the last step. The datapath is fed one sample at a time. It takes samples in pairs, even sample first. The whole lifting cascade runs once per pair, in the cycle that accepts the odd sample. The cascade works on 18-bit signed values.

Some steps read samples from ahead of the current pair. To keep the cascade causal, the even branch and the final odd branch are delayed in registers. The coefficients of pair m therefore come out when pair m+3 arrives. A frame-start input clears all history, so each frame is transformed as if silence came before it.

Top module: `dwt_lift_analysis`

## Requirements
- R1: While reset is held and after its release, `out_valid`, `lo_out` and `hi_out` are all zero until the first coefficient pair is produced.
- R2: After reset or `frame_start`, accepted samples (`in_valid` high) alternate even then odd. Once the odd sample of a pair is accepted, `out_valid` pulses high for exactly one cycle on the next clock edge, provided the frame has filled.
- R3: The first three pairs of a frame produce no output. The pair with index n≥3 (counted from 0) delivers the coefficients of pair n−3, so a frame of P pairs gives max(P−3,0) pulses.
- R4: Write e[k] and o[k] for the even and odd samples of pair k, with zero for k<0, and r(x,c) for the rounded product defined in R5. The steps are: o1[k]=o[k]+r(e[k],A); e2[k]=e[k]+r(o1[k+1],B0)+r(o1[k],B1); o3[k]=o1[k]+r(e2[k−1],C0)+r(e2[k−2],C1); e4[k]=e2[k]+r(o3[k+3],D0)+r(o3[k+2],D1); o5[k]=o3[k]+r(e4[k−3],F). Then lo[k]=r(e4[k],GL) and hi[k]=r(o5[k],GH).
- R5: A constant is an 18-bit signed mantissa M with a right shift S. The product is r(x,c)=floor((x·M+2^(S−1))/2^S). The (M,S) pairs are: A=(−101676,15), B0=(−80006,20), B1=(76546,18), C0=(85189,14), C1=(−108954,16), D0=(104101,15), D1=(79482,21), F=(82339,18), GL=(−126039,20), GH=(−68152,13).
- R6: The result of each lifting step is its full-precision sum saturated to the signed 18-bit range [−131072, 131071].
- R7: `lo_out` and `hi_out` are the gain products saturated to the signed 16-bit range [−32768, 32767].
- R8: `frame_start` clears all history and the pair phase, drops any sample offered in the same cycle, and forces `out_valid` low on the next cycle.
- R9: Idle cycles (`in_valid` low) and a lone even sample have no effect on the results. `lo_out` and `hi_out` hold their values except on the cycle after a pair completes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| frame_start | input | 1 | Clears history and phase; sample in same cycle dropped |
| in_valid | input | 1 | Qualifies `in_sample` |
| in_sample | input | 16 | Signed input sample |
| out_valid | output | 1 | One-cycle pulse marking a new coefficient pair |
| lo_out | output | 16 | Signed low-pass coefficient |
| hi_out | output | 16 | Signed high-pass coefficient |

## Verification
A coefficient pair is due one clock edge after the odd sample that completes pair n≥3, and it belongs to pair n−3. Inputs are driven on the falling edge, and outputs are also read on the falling edge, half a cycle after the registers update. The bench collects every `out_valid` pulse in order and counts them against max(P−3,0). It compares each pair with an index-domain model of R4 to R7 that knows nothing of the hardware delays. The frame-start and idle checks read `out_valid` and the held outputs on the falling edge right after the stimulus.

// File: rtl/dwt_lift_pkg.sv
package dwt_lift_pkg;
  localparam int SMP_W     = 16;
  localparam int ACC_W     = 18;
  localparam int COEF_W    = 18;
  localparam int SHR_W     = 5;
  localparam int TERM_W    = ACC_W + 6;
  localparam int SUM_W     = TERM_W + 2;
  localparam int PROD_W    = ACC_W + COEF_W + 1;
  localparam int LAG_PAIRS = 3;
  localparam int ACC_HI    = 2 ** (ACC_W - 1) - 1;
  localparam int ACC_LO    = -(2 ** (ACC_W - 1));
  localparam int SMP_HI    = 2 ** (SMP_W - 1) - 1;
  localparam int SMP_LO    = -(2 ** (SMP_W - 1));

  typedef logic signed [SMP_W-1:0]  smp_t;
  typedef logic signed [ACC_W-1:0]  acc_t;
  typedef logic signed [TERM_W-1:0] term_t;
  typedef logic signed [SUM_W-1:0]  sum_t;

  typedef struct packed {
    logic signed [COEF_W-1:0] mant;
    logic [SHR_W-1:0]         shr;
  } tap_t;

  // lifting constants: mantissa scaled by 2^17, shift = 17 - exponent
  localparam tap_t K_P1   = '{mant: -18'sd101676, shr: 5'd15};
  localparam tap_t K_U1A  = '{mant: -18'sd80006,  shr: 5'd20};
  localparam tap_t K_U1B  = '{mant:  18'sd76546,  shr: 5'd18};
  localparam tap_t K_P2A  = '{mant:  18'sd85189,  shr: 5'd14};
  localparam tap_t K_P2B  = '{mant: -18'sd108954, shr: 5'd16};
  localparam tap_t K_U2A  = '{mant:  18'sd104101, shr: 5'd15};
  localparam tap_t K_U2B  = '{mant:  18'sd79482,  shr: 5'd21};
  localparam tap_t K_P3   = '{mant:  18'sd82339,  shr: 5'd18};
  localparam tap_t K_GLO  = '{mant: -18'sd126039, shr: 5'd20};
  localparam tap_t K_GHI  = '{mant: -18'sd68152,  shr: 5'd13};

  // product with round-half-up before the right shift
  function automatic term_t tap_mul(input acc_t x, input tap_t t);
    logic signed [ACC_W+COEF_W-1:0] p;
    logic signed [PROD_W-1:0]       q;
    logic signed [PROD_W-1:0]       r;
    p = x * t.mant;
    q = {p[ACC_W+COEF_W-1], p} + (PROD_W'(1) << (t.shr - 5'd1));
    r = q >>> t.shr;
    return r[TERM_W-1:0];
  endfunction

  function automatic acc_t sat_acc(input sum_t v);
    if (v > ACC_HI)      return ACC_W'(ACC_HI);
    else if (v < ACC_LO) return ACC_W'(ACC_LO);
    else                 return v[ACC_W-1:0];
  endfunction

  function automatic smp_t sat_smp(input term_t v);
    if (v > SMP_HI)      return SMP_W'(SMP_HI);
    else if (v < SMP_LO) return SMP_W'(SMP_LO);
    else                 return v[SMP_W-1:0];
  endfunction

  // one lifting step: base plus two rounded terms, saturated
  function automatic acc_t lift_step(input acc_t base, input term_t a, input term_t b);
    sum_t s;
    s = {{(SUM_W-ACC_W){base[ACC_W-1]}}, base}
      + {{(SUM_W-TERM_W){a[TERM_W-1]}}, a}
      + {{(SUM_W-TERM_W){b[TERM_W-1]}}, b};
    return sat_acc(s);
  endfunction

  function automatic acc_t widen(input smp_t s);
    return {{(ACC_W-SMP_W){s[SMP_W-1]}}, s};
  endfunction
endpackage

// File: rtl/dwt_phase_split.sv
module dwt_phase_split
  import dwt_lift_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             frame_start,
  input  logic             in_valid,
  input  logic [SMP_W-1:0] in_sample,
  output logic             pair_fire,
  output acc_t             pair_even,
  output acc_t             pair_odd
);
  logic odd_phase;
  smp_t even_hold;

  assign pair_fire = in_valid && odd_phase && !frame_start;
  assign pair_even = widen(even_hold);
  assign pair_odd  = widen(smp_t'(in_sample));

  always_ff @(posedge clk) begin
    if (!rst_n || frame_start) begin
      odd_phase <= 1'b0;
      even_hold <= '0;
    end else if (in_valid) begin
      odd_phase <= !odd_phase;
      if (!odd_phase) even_hold <= smp_t'(in_sample);
    end
  end
endmodule

// File: rtl/dwt_lift_core.sv
module dwt_lift_core
  import dwt_lift_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic clear,
  input  logic fire,
  input  acc_t ev,
  input  acc_t od,
  output acc_t lo_pre,
  output acc_t hi_pre
);
  acc_t e_d1, o1_d1, e2_d1, e2_d2, o3_d1;
  acc_t o5_line [LAG_PAIRS];
  acc_t o1_w, e2_w, o3_w, e4_w, o5_w;

  // pair n: o1[n], e2[n-1], o3[n], e4[n-3], o5[n]
  always_comb begin
    o1_w = lift_step(od,    tap_mul(ev, K_P1),     '0);
    e2_w = lift_step(e_d1,  tap_mul(o1_w, K_U1A),  tap_mul(o1_d1, K_U1B));
    o3_w = lift_step(o1_w,  tap_mul(e2_w, K_P2A),  tap_mul(e2_d1, K_P2B));
    e4_w = lift_step(e2_d2, tap_mul(o3_w, K_U2A),  tap_mul(o3_d1, K_U2B));
    o5_w = lift_step(o3_w,  tap_mul(e4_w, K_P3),   '0);
  end

  assign lo_pre = e4_w;
  assign hi_pre = o5_line[LAG_PAIRS-1];

  always_ff @(posedge clk) begin
    if (!rst_n || clear) begin
      e_d1  <= '0;
      o1_d1 <= '0;
      e2_d1 <= '0;
      e2_d2 <= '0;
      o3_d1 <= '0;
    end else if (fire) begin
      e_d1  <= ev;
      o1_d1 <= o1_w;
      e2_d1 <= e2_w;
      e2_d2 <= e2_d1;
      o3_d1 <= o3_w;
    end
  end

  // alignment delay for the odd branch
  generate
    for (genvar g = 0; g < LAG_PAIRS; g++) begin : g_o5_dly
      always_ff @(posedge clk) begin
        if (!rst_n || clear)  o5_line[g] <= '0;
        else if (fire)        o5_line[g] <= (g == 0) ? o5_w : o5_line[(g == 0) ? 0 : g-1];
      end
    end
  endgenerate
endmodule

// File: rtl/dwt_gain_out.sv
module dwt_gain_out
  import dwt_lift_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clear,
  input  logic             fire,
  input  acc_t             lo_pre,
  input  acc_t             hi_pre,
  output logic             fill_done,
  output logic             out_valid,
  output logic [SMP_W-1:0] lo_out,
  output logic [SMP_W-1:0] hi_out
);
  localparam int CNT_W = $clog2(LAG_PAIRS + 1);
  logic [CNT_W-1:0] fill_cnt;

  assign fill_done = (fill_cnt == CNT_W'(LAG_PAIRS));

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      fill_cnt  <= '0;
      out_valid <= 1'b0;
      lo_out    <= '0;
      hi_out    <= '0;
    end else if (clear) begin
      fill_cnt  <= '0;
      out_valid <= 1'b0;
    end else begin
      out_valid <= fire && fill_done;
      if (fire && !fill_done) fill_cnt <= fill_cnt + 1'b1;
      if (fire && fill_done) begin
        lo_out <= sat_smp(tap_mul(lo_pre, K_GLO));
        hi_out <= sat_smp(tap_mul(hi_pre, K_GHI));
      end
    end
  end
endmodule

// File: rtl/dwt_lift_analysis.sv
module dwt_lift_analysis
  import dwt_lift_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             frame_start,
  input  logic             in_valid,
  input  logic [SMP_W-1:0] in_sample,
  output logic             out_valid,
  output logic [SMP_W-1:0] lo_out,
  output logic [SMP_W-1:0] hi_out
);
  logic pair_fire;
  logic fill_done;
  acc_t pair_even, pair_odd, lo_pre, hi_pre;

  dwt_phase_split u_split (
    .clk(clk), .rst_n(rst_n), .frame_start(frame_start),
    .in_valid(in_valid), .in_sample(in_sample),
    .pair_fire(pair_fire), .pair_even(pair_even), .pair_odd(pair_odd)
  );

  dwt_lift_core u_core (
    .clk(clk), .rst_n(rst_n), .clear(frame_start), .fire(pair_fire),
    .ev(pair_even), .od(pair_odd), .lo_pre(lo_pre), .hi_pre(hi_pre)
  );

  dwt_gain_out u_gain (
    .clk(clk), .rst_n(rst_n), .clear(frame_start), .fire(pair_fire),
    .lo_pre(lo_pre), .hi_pre(hi_pre), .fill_done(fill_done),
    .out_valid(out_valid), .lo_out(lo_out), .hi_out(hi_out)
  );
endmodule

// File: rtl/dwt_lift_chk.sv
module dwt_lift_chk
  import dwt_lift_pkg::*;
(
  input logic             clk,
  input logic             rst_n,
  input logic             frame_start,
  input logic             in_valid,
  input logic             pair_fire,
  input logic             out_valid,
  input logic [SMP_W-1:0] lo_out,
  input logic [SMP_W-1:0] hi_out
);
  logic [2:0] pairs_seen;

  always_ff @(posedge clk) begin
    if (!rst_n || frame_start)                       pairs_seen <= '0;
    else if (pair_fire && pairs_seen != 3'd7)        pairs_seen <= pairs_seen + 3'd1;
  end

  // R2
  pair_in_chk: assert property (@(posedge clk) disable iff (!rst_n)
    pair_fire |-> in_valid);

  // R2
  valid_after_pair_chk: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> $past(pair_fire));

  // R2
  single_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |=> !out_valid);

  // R3
  fill_chk: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> (pairs_seen > 3'(LAG_PAIRS)));

  // R8
  restart_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    frame_start |=> !out_valid);

  // R8
  restart_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
    frame_start |-> !pair_fire);

  // R9
  hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !pair_fire |=> ($stable(lo_out) && $stable(hi_out)));
endmodule

bind dwt_lift_analysis dwt_lift_chk u_chk (
  .clk(clk), .rst_n(rst_n), .frame_start(frame_start), .in_valid(in_valid),
  .pair_fire(pair_fire), .out_valid(out_valid), .lo_out(lo_out), .hi_out(hi_out)
);

// File: tb/tb_dwt_lift_analysis.sv
`timescale 1ns/1ps
module tb_dwt_lift_analysis;
  localparam int MAXP = 64;
  localparam int OFF  = 4;
  localparam int ASZ  = MAXP + 16;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic frame_start = 1'b0;
  logic in_valid = 1'b0;
  logic [15:0] in_sample = '0;
  logic out_valid;
  logic [15:0] lo_out, hi_out;

  int total = 0;
  int bad = 0;
  bit finished = 0;

  longint cap_lo [MAXP];
  longint cap_hi [MAXP];
  int cap_n = 0;
  longint smp [2*MAXP];

  always #2.5 clk = ~clk;

  dwt_lift_analysis dut (
    .clk(clk), .rst_n(rst_n), .frame_start(frame_start), .in_valid(in_valid),
    .in_sample(in_sample), .out_valid(out_valid), .lo_out(lo_out), .hi_out(hi_out)
  );

  always @(negedge clk) begin
    if (rst_n && out_valid && cap_n < MAXP) begin
      cap_lo[cap_n] = longint'($signed(lo_out));
      cap_hi[cap_n] = longint'($signed(hi_out));
      cap_n = cap_n + 1;
    end
  end

  task automatic check(input string req, input string what, input longint act, input longint exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  // independent index-domain model (R4..R7)
  function automatic longint rm(input longint x, input longint m, input int sh);
    return (x * m + (longint'(1) <<< (sh - 1))) >>> sh;
  endfunction

  function automatic longint cl(input longint v, input int bits);
    longint hi = (longint'(1) <<< (bits - 1)) - 1;
    longint lo = -(longint'(1) <<< (bits - 1));
    if (v > hi) return hi;
    if (v < lo) return lo;
    return v;
  endfunction

  function automatic longint gen(input int kind, input int i);
    case (kind)
      0: return (i == 0) ? 1000 : 0;
      1: return longint'(i * 700 - 11000);
      2: return longint'(((i * 40503) ^ (i * i * 97 + 311)) % 20000) - 10000;
      3: return (i % 2 == 0) ? 32767 : -32768;
      default: return (i % 4 < 2) ? -32768 : 32767;
    endcase
  endfunction

  task automatic drive_sample(input longint v);
    @(negedge clk);
    in_valid  = 1'b1;
    in_sample = 16'(v);
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      in_valid = 1'b0;
    end
  endtask

  // one frame: start, P pairs, compare against the model
  task automatic run_frame(input string tag, input int P, input int kind, input int gap, input bit junk_on_start);
    longint e[ASZ]; longint o[ASZ]; longint o1[ASZ]; longint e2[ASZ];
    longint o3[ASZ]; longint e4[ASZ]; longint o5[ASZ];
    int nexp;
    @(negedge clk);
    frame_start = 1'b1;
    in_valid    = junk_on_start;
    in_sample   = 16'h5A5A;
    #1 cap_n = 0;
    @(negedge clk);
    frame_start = 1'b0;
    in_valid    = 1'b0;
    // R8: the cycle after a frame start carries no pulse
    check("R8", {tag, " valid after start"}, longint'(out_valid), 0);
    for (int i = 0; i < 2*P; i++) begin
      smp[i] = gen(kind, i);
      drive_sample(smp[i]);
      if (gap > 0) idle(gap);
    end
    idle(6);
    for (int i = 0; i < ASZ; i++) begin
      int k = i - OFF;
      e[i] = (k >= 0 && k < P) ? smp[2*k]   : 0;
      o[i] = (k >= 0 && k < P) ? smp[2*k+1] : 0;
      o1[i] = 0; e2[i] = 0; o3[i] = 0; e4[i] = 0; o5[i] = 0;
    end
    for (int i = 0; i < ASZ; i++) o1[i] = cl(o[i] + rm(e[i], -101676, 15), 18);
    for (int i = 0; i < ASZ-1; i++)
      e2[i] = cl(e[i] + rm(o1[i+1], -80006, 20) + rm(o1[i], 76546, 18), 18);
    for (int i = 2; i < ASZ; i++)
      o3[i] = cl(o1[i] + rm(e2[i-1], 85189, 14) + rm(e2[i-2], -108954, 16), 18);
    for (int i = 0; i < ASZ-3; i++)
      e4[i] = cl(e2[i] + rm(o3[i+3], 104101, 15) + rm(o3[i+2], 79482, 21), 18);
    for (int i = 3; i < ASZ; i++)
      o5[i] = cl(o3[i] + rm(e4[i-3], 82339, 18), 18);
    nexp = (P > 3) ? P - 3 : 0;
    // R3: pulse count per frame
    check("R3", {tag, " pulse count"}, cap_n, nexp);
    for (int m = 0; m < nexp && m < cap_n; m++) begin
      // R4 R5 R6 R7: coefficient values
      check("R4", $sformatf("%s lo[%0d]", tag, m), cap_lo[m], cl(rm(e4[m+OFF], -126039, 20), 16));
      check("R7", $sformatf("%s hi[%0d]", tag, m), cap_hi[m], cl(rm(o5[m+OFF], -68152, 13), 16));
    end
  endtask

  task automatic t_reset();
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    check("R1", "valid in reset", longint'(out_valid), 0);
    rst_n = 1'b1;
    idle(2);
    check("R1", "valid after reset", longint'(out_valid), 0);
    check("R1", "lo after reset", longint'(lo_out), 0);
    check("R1", "hi after reset", longint'(hi_out), 0);
  endtask

  task automatic t_short_frame();
    // R3: three pairs only, no output at all
    run_frame("short", 3, 2, 0, 1'b0);
  endtask

  task automatic t_restart();
    // R8: junk pairs and a lone even sample, then a start with a sample offered
    for (int i = 0; i < 11; i++) drive_sample(longint'(i * 3001 - 9000));
    run_frame("restart", 10, 2, 0, 1'b1);
  endtask

  task automatic t_hold();
    longint lo0, hi0;
    idle(1);
    lo0 = longint'(lo_out);
    hi0 = longint'(hi_out);
    cap_n = 0;
    idle(4);
    drive_sample(12345);
    idle(5);
    // R9: a lone even sample and idle cycles change nothing
    check("R9", "no pulse on lone even", cap_n, 0);
    check("R9", "lo held", longint'(lo_out), lo0);
    check("R9", "hi held", longint'(hi_out), hi0);
  endtask

  initial begin
    #(200000 * 5);
    if (!finished) begin
      total++;
      bad++;
      $display("FAIL watchdog: actual=timeout expected=completion");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    t_reset();
    run_frame("impulse", 8, 0, 0, 1'b0);
    run_frame("ramp_gap", 12, 1, 2, 1'b0);
    run_frame("mixed", 40, 2, 0, 1'b0);
    run_frame("fullscale", 16, 3, 0, 1'b0);
    run_frame("square", 16, 4, 1, 1'b0);
    t_short_frame();
    t_restart();
    t_hold();
    finished = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule